// File: doc/BRIEF.md
# Privilege and Priority Mask Registers

This unit holds two special registers of a processor core: an exception priority mask and a two-bit mode control word. Software reaches them through a small register port. `reg_sel` picks the register, `wr_en` writes `wr_data` on a clock edge, and `rd_data` returns the selected register combinationally. The core reports its execution mode on `in_handler`. It also pulses `exc_entry` when an exception is taken and `exc_return` when a handler finishes. `ret_to_thread` tells the unit whether that return lands in thread mode.

From this state the unit drives `use_psp`, which selects the main stack (0) or the process stack (1). It also drives `thread_unpriv`, the thread privilege level. For any priority value offered on `req_prio`, `req_blocked` reports whether the current mask holds that exception back. Numerically larger priority values are less urgent. Only the upper `PRIO_W-PRIO_LSB` bits of the mask are stored. The default parameters (8-bit priority, `PRIO_LSB`=3) keep bits [7:3].

Top module: `priv_mask_regs`

## Requirements
- R1: After reset, both registers read 0, `use_psp`=0, `thread_unpriv`=0, and `req_blocked`=0 for every `req_prio`.
- R2: With `reg_sel`=0 the mask register is addressed. On read, bits [31:8] and the unimplemented bits [PRIO_LSB-1:0] are 0, and writes to those bits have no effect. With default parameters, writing 0xFFFFFFFF reads back 0xF8.
- R3: `req_blocked` is 1 exactly when the stored mask is nonzero and `req_prio` is greater than or equal to it. A mask of 0 blocks no priority value.
- R4: `req_blocked` follows the stored mask and `req_prio` with no register in between. The first cycle after a mask write already uses the new mask.
- R5: With `reg_sel`=1 the control register is addressed. Bit 0 is the thread privilege level (0 privileged, 1 unprivileged) and drives `thread_unpriv`. Bits [31:2] read as 0.
- R6: Control bit 1 selects the thread stack (0 main, 1 process). In thread mode `use_psp` equals that bit.
- R7: While `in_handler`=1, control bit 1 reads as 0, a write to it has no effect, and `use_psp`=0. A write to bit 0 still takes effect in handler mode.
- R8: An `exc_entry` pulse taken from thread mode stores the current stack-select bit and clears it. An `exc_return` pulse with `ret_to_thread`=1 restores the stored bit, so the thread resumes on the stack it left.
- R9: While in thread mode with control bit 0 set, software writes to either register have no effect.
- R10: An `exc_entry` taken while already in handler mode leaves the stored thread stack-select bit unchanged. An `exc_return` with `ret_to_thread`=0 leaves bit 1 at 0. Entry and return pulses take precedence over a same-cycle software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_handler | input | 1 | 1 while the core runs an exception handler |
| exc_entry | input | 1 | One-cycle pulse when an exception is taken |
| exc_return | input | 1 | One-cycle pulse when a handler returns |
| ret_to_thread | input | 1 | With `exc_return`, 1 when the return lands in thread mode |
| reg_sel | input | 1 | 0 selects the mask register, 1 the control register |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | DATA_W | Software write data |
| rd_data | output | DATA_W | Read data of the selected register |
| req_prio | input | PRIO_W | Priority value of an incoming exception |
| req_blocked | output | 1 | 1 when the mask holds that exception back |
| use_psp | output | 1 | 1 selects the process stack, 0 the main stack |
| thread_unpriv | output | 1 | Thread privilege level, 1 unprivileged |

## Verification
A lost or stale stack-select bit shows up at `use_psp` in the first thread-mode cycle after an exception return. A privilege bit that should not have changed shows up at once on `thread_unpriv` and in the control read. The stored mask is visible combinationally on `req_blocked` and on a read in the cycle after the write. The bench therefore probes these ports immediately after each write or pulse. It also probes them after the mode changes back. This catches a corruption hidden by handler mode, which only appears when thread mode resumes.

// File: rtl/priv_mask_regs.sv
module priv_mask_regs #(
  parameter int DATA_W   = 32,
  parameter int PRIO_W   = 8,
  parameter int PRIO_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_handler,
  input  logic              exc_entry,
  input  logic              exc_return,
  input  logic              ret_to_thread,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              req_blocked,
  output logic              use_psp,
  output logic              thread_unpriv
);
  localparam int IMPL_W = PRIO_W - PRIO_LSB;

  logic [IMPL_W-1:0] mask_q;
  logic              priv_q;
  logic              spsel_q;
  logic              saved_q;
  logic [PRIO_W-1:0] mask_full;
  logic              sw_ok;

  assign mask_full = PRIO_W'(mask_q) << PRIO_LSB;
  assign sw_ok     = wr_en && (in_handler || !priv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (sw_ok && !reg_sel) begin
      mask_q <= wr_data[PRIO_W-1:PRIO_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q  <= 1'b0;
      spsel_q <= 1'b0;
      saved_q <= 1'b0;
    end else begin
      if (sw_ok && reg_sel) priv_q <= wr_data[0];
      if (exc_entry) begin
        if (!in_handler) saved_q <= spsel_q;
        spsel_q <= 1'b0;
      end else if (exc_return) begin
        spsel_q <= ret_to_thread ? saved_q : 1'b0;
      end else if (sw_ok && reg_sel && !in_handler) begin
        spsel_q <= wr_data[1];
      end
    end
  end

  assign use_psp       = !in_handler && spsel_q;
  assign thread_unpriv = priv_q;
  assign req_blocked   = (mask_q != '0) && (req_prio >= mask_full);
  assign rd_data       = reg_sel ? DATA_W'({use_psp, priv_q}) : DATA_W'(mask_full);
endmodule

// File: rtl/priv_mask_regs_chk.sv
module priv_mask_regs_chk #(
  parameter int DATA_W   = 32,
  parameter int PRIO_W   = 8,
  parameter int PRIO_LSB = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_handler,
  input logic                   exc_entry,
  input logic                   exc_return,
  input logic                   ret_to_thread,
  input logic                   reg_sel,
  input logic                   wr_en,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   req_blocked,
  input logic                   use_psp,
  input logic [PRIO_W-PRIO_LSB-1:0] mask_q,
  input logic                   priv_q,
  input logic                   spsel_q,
  input logic                   saved_q
);
  localparam logic [DATA_W-1:0] MASK_BITS =
    DATA_W'(((1 << PRIO_W) - 1) & ~((1 << PRIO_LSB) - 1));

  p_mask_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (rd_data & ~MASK_BITS) == '0);
  p_ctrl_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> rd_data[DATA_W-1:2] == '0);
  p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !req_blocked);
  p_handler_msp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> !use_psp);
  p_unpriv_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_handler && priv_q && wr_en && !exc_entry && !exc_return)
      |=> ($stable(mask_q) && $stable(priv_q) && $stable(spsel_q)));
  p_entry_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !spsel_q);
  p_entry_save_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && !in_handler) |=> saved_q == $past(spsel_q));
  p_return_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && ret_to_thread && !exc_entry) |=> spsel_q == $past(saved_q));
  p_nested_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_entry && in_handler) |=> $stable(saved_q));
endmodule

bind priv_mask_regs priv_mask_regs_chk #(
  .DATA_W(DATA_W), .PRIO_W(PRIO_W), .PRIO_LSB(PRIO_LSB)
) i_priv_mask_regs_chk (
  .clk(clk), .rst_n(rst_n), .in_handler(in_handler), .exc_entry(exc_entry),
  .exc_return(exc_return), .ret_to_thread(ret_to_thread), .reg_sel(reg_sel),
  .wr_en(wr_en), .rd_data(rd_data), .req_blocked(req_blocked), .use_psp(use_psp),
  .mask_q(mask_q), .priv_q(priv_q), .spsel_q(spsel_q), .saved_q(saved_q)
);

// File: tb/test_priv_mask_regs.sv
module test_priv_mask_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_handler = 1'b0, exc_entry = 1'b0, exc_return = 1'b0, ret_to_thread = 1'b0;
  logic        reg_sel = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  req_prio = '0;
  logic        req_blocked, use_psp, thread_unpriv;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_mask_regs i_priv_mask_regs (
    .clk(clk), .rst_n(rst_n), .in_handler(in_handler), .exc_entry(exc_entry),
    .exc_return(exc_return), .ret_to_thread(ret_to_thread), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .req_prio(req_prio),
    .req_blocked(req_blocked), .use_psp(use_psp), .thread_unpriv(thread_unpriv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic pulse_entry();
    @(negedge clk);
    exc_entry = 1'b1;
    @(negedge clk);
    exc_entry = 1'b0; in_handler = 1'b1;
    #1;
  endtask

  task automatic pulse_return(input logic to_thread);
    @(negedge clk);
    exc_return = 1'b1; ret_to_thread = to_thread;
    @(negedge clk);
    exc_return = 1'b0; ret_to_thread = 1'b0;
    if (to_thread) in_handler = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    read_reg(1'b0, v); check("R1 mask after reset", v, 0);
    read_reg(1'b1, v); check("R1 control after reset", v, 0);
    check("R1 use_psp", 32'(use_psp), 0);
    check("R1 thread_unpriv", 32'(thread_unpriv), 0);
    req_prio = 8'hFF; #1; check("R1 no blocking at 0xFF", 32'(req_blocked), 0);
    req_prio = 8'h00; #1; check("R1 no blocking at 0x00", 32'(req_blocked), 0);
  endtask

  task automatic t_mask_bits();
    logic [31:0] v;
    sw_write(1'b0, 32'hFFFF_FFFF);
    read_reg(1'b0, v); check("R2 unimplemented bits zero", v, 32'hF8);
    sw_write(1'b0, 32'h0000_0047);
    read_reg(1'b0, v); check("R2 low bits dropped", v, 32'h40);
  endtask

  task automatic t_blocking();
    req_prio = 8'h40; #1; check("R3 equal blocked", 32'(req_blocked), 1);
    req_prio = 8'h3F; #1; check("R3 more urgent passes", 32'(req_blocked), 0);
    req_prio = 8'hFF; #1; check("R3 least urgent blocked", 32'(req_blocked), 1);
    req_prio = 8'h00; #1; check("R3 most urgent passes", 32'(req_blocked), 0);
    sw_write(1'b0, 32'h0);
    req_prio = 8'hFF; #1; check("R3 zero mask passes all", 32'(req_blocked), 0);
  endtask

  task automatic t_write_timing();
    sw_write(1'b0, 32'h40);
    req_prio = 8'h20; #1; check("R4 before write", 32'(req_blocked), 0);
    sw_write(1'b0, 32'h20);
    check("R4 next cycle uses new mask", 32'(req_blocked), 1);
  endtask

  task automatic t_control();
    logic [31:0] v;
    sw_write(1'b1, 32'hFFFF_FFFE);
    read_reg(1'b1, v); check("R5 reserved control bits", v, 32'h2);
    check("R6 process stack in thread", 32'(use_psp), 1);
    check("R5 privileged", 32'(thread_unpriv), 0);
    @(negedge clk); in_handler = 1'b1; #1;
    read_reg(1'b1, v); check("R7 bit1 reads zero in handler", v, 32'h0);
    check("R7 main stack in handler", 32'(use_psp), 0);
    sw_write(1'b1, 32'h1);
    read_reg(1'b1, v); check("R7 bit0 writable in handler", v, 32'h1);
    check("R5 unpriv output", 32'(thread_unpriv), 1);
    sw_write(1'b1, 32'h0);
    @(negedge clk); in_handler = 1'b0; #1;
    check("R7 handler write to bit1 ignored", 32'(use_psp), 1);
  endtask

  task automatic t_exceptions();
    logic [31:0] v;
    pulse_entry();
    check("R8 main stack after entry", 32'(use_psp), 0);
    pulse_entry();
    pulse_return(1'b0);
    read_reg(1'b1, v); check("R10 return to handler", v, 32'h0);
    pulse_return(1'b1);
    check("R10 nested entry kept saved bit", 32'(use_psp), 1);
    sw_write(1'b1, 32'h0);
    pulse_entry();
    pulse_return(1'b1);
    check("R8 restore main stack", 32'(use_psp), 0);
    @(negedge clk);
    reg_sel = 1'b1; wr_data = 32'h2; wr_en = 1'b1; exc_entry = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; exc_entry = 1'b0;
    #1;
    check("R10 entry beats write", 32'(use_psp), 0);
  endtask

  task automatic t_unpriv();
    logic [31:0] v;
    sw_write(1'b1, 32'h2);
    sw_write(1'b0, 32'h60);
    sw_write(1'b1, 32'h3);
    check("R9 now unprivileged", 32'(thread_unpriv), 1);
    sw_write(1'b0, 32'h80);
    read_reg(1'b0, v); check("R9 mask write ignored", v, 32'h60);
    sw_write(1'b1, 32'h0);
    read_reg(1'b1, v); check("R9 control write ignored", v, 32'h3);
    check("R9 stack kept", 32'(use_psp), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mask_bits();
    t_blocking();
    t_write_timing();
    t_control();
    t_exceptions();
    t_unpriv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule